// File: doc/BRIEF.md
# Two-Map Banked MMU with Sync-Acknowledge Exit

This block translates the 16-bit addresses of an 8-bit CPU onto a 32K base RAM, a 64K expansion RAM and the rest of the machine's ROM and I/O space. A write-only control byte selects one of two memory maps. In the default map, base RAM fills the lower half of the address space, and one 4K page of expansion RAM, chosen by a bank number, appears in a fixed window. Every other address is handed out unchanged, flagged as unmapped, for outside ROM and I/O decoding. In the flat map, every CPU address goes straight to expansion RAM, and the control byte can no longer be reached.

The flat map has no exit through a write. Software leaves it by executing the CPU's wait-for-interrupt instruction. The CPU then reports the sync-acknowledge state on its bus-status pins (BA high, BS low). The block clears the whole control byte when it sees that state, and it pulls the active-low fast-interrupt request so the CPU leaves its wait. Whenever BA is high, translation falls back to the default map at once, without waiting for the register to clear.

Top module: `sync_exit_mmu`

## Requirements
- R1: After synchronous reset the control byte is zero (bank 0, default map, interrupt enabled) and `firq_n` is high.
- R2: A cycle with `cpu_rw`=0, `ba`=0, `cpu_addr`=0xEFFC in the default map loads `cpu_data` into the control byte on that clock edge. Bits 3..0 are the bank number, and it is visible from the next cycle.
- R3: In the default map, addresses 0x0000-0x7FFF assert `base_sel` with `phys_addr` equal to `cpu_addr`. Exactly one of `base_sel`, `xram_sel` and `unmapped` is high in every cycle.
- R4: In the default map, addresses 0x9000-0x9FFF assert `xram_sel` with `phys_addr` = {bank, `cpu_addr`[11:0]}.
- R5: In the default map, all other addresses (0x8000-0x8FFF and 0xA000-0xFFFF, 0xEFFC included) assert `unmapped` with `phys_addr` equal to `cpu_addr`.
- R6: With control bit 6 (flat select) set and `ba`=0, every address asserts `xram_sel` with `phys_addr` equal to `cpu_addr`. A write to 0xEFFC leaves the control byte unchanged.
- R7: A cycle with `ba`=1 and `bs`=0 clears the entire control byte on that edge, so the default map with bank 0 holds from the next cycle.
- R8: On the first cycle of sync acknowledge, with control bit 5 (interrupt disable) clear, `firq_n` goes low from the next cycle. It stays low while `ba`=1 and returns high after the first edge with `ba`=0.
- R9: If bit 5 was set when sync acknowledge began, `firq_n` stays high for the whole wait, but the control byte is still cleared.
- R10: While `ba`=1, with any `bs`, translation follows the default map with the stored bank, even if flat select is set. Halt acknowledge (`ba`=1, `bs`=1) neither clears the control byte nor lowers `firq_n`.
- R11: Control bits 4 and 7 have no effect on translation. A byte written with them set behaves as the same byte with them clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one rising edge ends each bus cycle |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| ba | input | 1 | CPU bus-available status |
| bs | input | 1 | CPU bus-state status |
| phys_addr | output | 16 | Translated address for the selected target |
| base_sel | output | 1 | Base RAM selected |
| xram_sel | output | 1 | Expansion RAM selected |
| unmapped | output | 1 | Address passed through for outside decoding |
| firq_n | output | 1 | Active-low fast-interrupt request |

## Verification
The bench goes after the exit path cycle by cycle. A design that lowers the interrupt a cycle early or late, or holds it after BA drops, fails R8. A design that reads the disable bit after the register clears fires the interrupt on the second wait cycle, which R9 catches. Halt acknowledge is driven while the flat map is active, to catch a design that keeps flat translation under BA or clears the register on the wrong status code. Writes to the control address inside the flat map, and unused bits 4 and 7, show up as wrong page selection in later reads.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    TGT_BASE = 2'd0,
    TGT_XRAM = 2'd1,
    TGT_OPEN = 2'd2
  } mmu_tgt_e;
endpackage

// File: rtl/mmu_ctrl_reg.sv
module mmu_ctrl_reg #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hEFFC,
  parameter int FLAT_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_rw,
  input  logic              ba,
  input  logic              sync_clr,
  output logic [DATA_W-1:0] ctrl_q
);
  // The register is only reachable while the CPU owns the bus in the default map.
  logic wr_hit;
  assign wr_hit = !cpu_rw && !ba && !ctrl_q[FLAT_BIT] && (cpu_addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst)           ctrl_q <= '0;
    else if (sync_clr) ctrl_q <= '0;
    else if (wr_hit)   ctrl_q <= cpu_data;
  end

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sync_clr |=> (ctrl_q == '0)); // R7
  AST_FLAT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[FLAT_BIT] && !ba) |=> $stable(ctrl_q)); // R6
endmodule

// File: rtl/mmu_sync_irq.sv
module mmu_sync_irq (
  input  logic clk,
  input  logic rst,
  input  logic ba,
  input  logic bs,
  input  logic fdis,
  output logic sync_clr,
  output logic firq_n
);
  logic sync_ack, sync_q, firq_q;
  assign sync_ack = ba && !bs;
  assign sync_clr = sync_ack;
  assign firq_n   = !firq_q;

  // Arm only on the first acknowledge cycle: the disable bit is gone after that edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      firq_q <= 1'b0;
    end else begin
      sync_q <= sync_ack;
      if (!ba)
        firq_q <= 1'b0;
      else if (sync_ack && !sync_q && !fdis)
        firq_q <= 1'b1;
    end
  end

  AST_FIRQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !ba |=> firq_n); // R8
  AST_FIRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (sync_ack && !sync_q && !fdis) |=> !firq_n); // R8
  AST_FIRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (sync_ack && !sync_q && fdis && firq_n) |=> firq_n); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ba && bs && firq_n) |=> firq_n); // R10
endmodule

// File: rtl/mmu_addr_xlat.sv
module mmu_addr_xlat
  import mmu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 4,
  parameter int WIN_W    = 12,
  parameter int BASE_W   = 15,
  parameter int WIN_PAGE = 9
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BANK_W-1:0] bank,
  input  logic              flat_eff,
  output logic [ADDR_W-1:0] phys_addr,
  output mmu_tgt_e          tgt
);
  localparam int PAGE_W = ADDR_W - WIN_W;
  localparam logic [PAGE_W-1:0] WIN_TAG = PAGE_W'(WIN_PAGE);

  logic in_base, in_win;
  assign in_base = (cpu_addr[ADDR_W-1:BASE_W] == '0);
  assign in_win  = (cpu_addr[ADDR_W-1:WIN_W] == WIN_TAG);

  always_comb begin
    phys_addr = cpu_addr;
    tgt       = TGT_OPEN;
    if (flat_eff) begin
      tgt = TGT_XRAM;
    end else if (in_base) begin
      tgt = TGT_BASE;
    end else if (in_win) begin
      tgt       = TGT_XRAM;
      phys_addr = ADDR_W'({bank, cpu_addr[WIN_W-1:0]});
    end
  end
endmodule

// File: rtl/sync_exit_mmu.sv
module sync_exit_mmu
  import mmu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 4,
  parameter int WIN_W    = 12,
  parameter int BASE_W   = 15,
  parameter int WIN_PAGE = 9,
  parameter logic [15:0] REG_ADDR = 16'hEFFC,
  parameter int FLAT_BIT = 6,
  parameter int FDIS_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_rw,
  input  logic              ba,
  input  logic              bs,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              base_sel,
  output logic              xram_sel,
  output logic              unmapped,
  output logic              firq_n
);
  logic [DATA_W-1:0] ctrl_q;
  logic              sync_clr, flat_eff, ctrl_unused;
  mmu_tgt_e          tgt;

  // BA alone drops to the default map, ahead of the register clear.
  assign flat_eff    = ctrl_q[FLAT_BIT] && !ba;
  assign ctrl_unused = ^ctrl_q;

  mmu_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(ADDR_W'(REG_ADDR)), .FLAT_BIT(FLAT_BIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_rw(cpu_rw),
    .ba(ba), .sync_clr(sync_clr), .ctrl_q(ctrl_q)
  );

  mmu_sync_irq u_irq (
    .clk(clk), .rst(rst), .ba(ba), .bs(bs), .fdis(ctrl_q[FDIS_BIT]),
    .sync_clr(sync_clr), .firq_n(firq_n)
  );

  mmu_addr_xlat #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .WIN_W(WIN_W), .BASE_W(BASE_W), .WIN_PAGE(WIN_PAGE)
  ) u_xlat (
    .cpu_addr(cpu_addr), .bank(ctrl_q[BANK_W-1:0]), .flat_eff(flat_eff),
    .phys_addr(phys_addr), .tgt(tgt)
  );

  assign base_sel = (tgt == TGT_BASE);
  assign xram_sel = (tgt == TGT_XRAM);
  assign unmapped = (tgt == TGT_OPEN);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $countones({base_sel, xram_sel, unmapped}) == 1); // R3
  AST_BA_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (ba && cpu_addr[ADDR_W-1:BASE_W] == '0) |-> base_sel); // R10
endmodule

// File: tb/sync_exit_mmu_tb_top.sv
module sync_exit_mmu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic cpu_rw = 1'b1, ba = 1'b0, bs = 1'b0;
  logic [15:0] phys_addr;
  logic base_sel, xram_sel, unmapped, firq_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_exit_mmu dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_rw(cpu_rw),
    .ba(ba), .bs(bs), .phys_addr(phys_addr), .base_sel(base_sel), .xram_sel(xram_sel),
    .unmapped(unmapped), .firq_n(firq_n)
  );

  typedef struct {
    logic [15:0] phys;
    logic [2:0]  sel;   // {base, xram, unmapped}
    logic        firq_n;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // Reference model state, kept from the requirements only.
  logic [7:0] m_ctrl = '0;
  logic m_firq = 1'b0, m_sync = 1'b0;

  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic rw,
                     input logic b_a, input logic b_s, input string tag);
    exp_t e;
    logic flat, sync;
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = rw; ba = b_a; bs = b_s;
    flat = m_ctrl[6] && !b_a;
    e.phys = a;
    if (flat)                    e.sel = 3'b010;
    else if (a < 16'h8000)       e.sel = 3'b100;
    else if (a[15:12] == 4'h9) begin
      e.sel = 3'b010; e.phys = {m_ctrl[3:0], a[11:0]};
    end else                     e.sel = 3'b001;
    e.firq_n = !m_firq;
    e.tag = tag;
    exp_q.push_back(e);
    sync = b_a && !b_s;
    if (!b_a) m_firq = 1'b0;
    else if (sync && !m_sync && !m_ctrl[5]) m_firq = 1'b1;
    m_sync = sync;
    if (sync) m_ctrl = '0;
    else if (!b_a && !rw && a == 16'hEFFC && !m_ctrl[6]) m_ctrl = d;
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    cyc(a, 8'h00, 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic wr_ctrl(input logic [7:0] d, input string tag);
    cyc(16'hEFFC, d, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic chk(input string what, input string tag, input logic [15:0] act,
                     input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Monitor: pops one expectation per cycle, sampled mid-low-phase.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk("phys_addr", e.tag, phys_addr, e.phys);
        chk("selects", e.tag, {13'd0, base_sel, xram_sel, unmapped}, {13'd0, e.sel});
        chk("firq_n", e.tag, {15'd0, firq_n}, {15'd0, e.firq_n});
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    rd(16'h9000, "R1"); rd(16'h9ABC, "R1");
    // R3 base RAM
    rd(16'h0000, "R3"); rd(16'h7FFF, "R3"); rd(16'h1234, "R3");
    // R5 pass-through
    rd(16'h8000, "R5"); rd(16'hA000, "R5"); rd(16'hEFFC, "R5"); rd(16'hFFFF, "R5");
    // R2 / R4 bank selection
    wr_ctrl(8'h05, "R2"); rd(16'h9123, "R4");
    wr_ctrl(8'h0F, "R2"); rd(16'h9FFF, "R4"); rd(16'h8FFF, "R5");
    // R11 unused bits 4 and 7
    wr_ctrl(8'h93, "R11"); rd(16'h9001, "R11"); rd(16'h1000, "R11");
    // R6 flat map, register locked
    wr_ctrl(8'h42, "R6"); rd(16'h1234, "R6"); rd(16'h9000, "R6"); rd(16'hEFFC, "R6");
    wr_ctrl(8'h00, "R6"); rd(16'h8000, "R6");
    // R10 halt acknowledge in the flat map
    cyc(16'h9456, 8'h00, 1'b1, 1'b1, 1'b1, "R10");
    cyc(16'h0100, 8'h00, 1'b1, 1'b1, 1'b1, "R10");
    cyc(16'hC000, 8'h00, 1'b1, 1'b1, 1'b1, "R10");
    rd(16'h5555, "R10");
    // R7 / R8 sync exit with interrupt enabled
    cyc(16'hFFF8, 8'h00, 1'b1, 1'b1, 1'b0, "R7");
    cyc(16'hFFF8, 8'h00, 1'b1, 1'b1, 1'b0, "R8");
    cyc(16'h9000, 8'h00, 1'b1, 1'b1, 1'b0, "R8");
    rd(16'h9000, "R8"); rd(16'h1234, "R7");
    // R9 sync exit with interrupt disabled
    wr_ctrl(8'h60, "R9"); rd(16'h4000, "R9");
    cyc(16'hFFF8, 8'h00, 1'b1, 1'b1, 1'b0, "R9");
    cyc(16'hFFF8, 8'h00, 1'b1, 1'b1, 1'b0, "R9");
    cyc(16'hFFF8, 8'h00, 1'b1, 1'b1, 1'b0, "R9");
    rd(16'h4000, "R9"); rd(16'h9777, "R9");
    // R8 again from the default map with a bank set
    wr_ctrl(8'h0A, "R8"); cyc(16'h9321, 8'h00, 1'b1, 1'b1, 1'b0, "R8");
    cyc(16'h9321, 8'h00, 1'b1, 1'b1, 1'b0, "R8"); rd(16'h9321, "R8"); rd(16'h9321, "R8");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule